// File: doc/BRIEF.md
# Macro Sequencer Arithmetic and Bitfield Unit

This unit is the execution stage of a small macro sequencer. Each cycle it decodes a 32-bit instruction word together with two source register values and produces a 32-bit result combinationally. It covers register-register arithmetic and logic, an add with a signed immediate, three bitfield operations, and a read from an external engine register file. The read is performed by driving an address out and taking the returned data in the same cycle.

The only state is a one-bit carry flag. It links multi-word additions and subtractions across instructions, and it moves only when the sequencer asserts the execute enable for an arithmetic function. The sequencer clears it at program start through a dedicated clear input. Instruction fetch, destination handling, branching and the register file itself lie outside this block.

Top module: `macro_alu`

## Requirements
- R1: Operation class is instruction bits 2:0. Class 1 returns A plus the immediate, where the immediate is instruction bits 31:14 sign-extended to 32 bits.
- R2: In class 0 the function is bits 21:17. Functions 8, 9, 10, 11 and 12 return A XOR B, A OR B, A AND B, A AND NOT B, and NOT (A AND B), in that order.
- R3: Function 0 returns A+B and function 1 returns A+B+carry. On execute, both set the carry to bit 32 of the full sum.
- R4: Function 2 returns A-B and function 3 returns A-B-1 when the carry is clear (A-B when it is set). On execute, both set the carry to 1 when no borrow occurs and to 0 when one does.
- R5: The carry changes only on a clock edge with execute enable high and a class 0 function of 0 to 3. All other classes, functions and idle cycles hold it.
- R6: Reset clears the carry. A high carry-clear input clears it on the next edge and takes priority over an arithmetic update in the same cycle.
- R7: Class 2 takes size bits from B, starting at the source offset (bits 21:17). It writes them into A at the destination offset (bits 31:27) and keeps every other bit of A. The field size is bits 26:22.
- R8: Class 3 shifts B right logically by the value of A, masks it to the field size, and shifts it left by the destination offset. A value of A of 32 or more gives 0.
- R9: Class 4 shifts B right by the source offset, masks it to the field size, and shifts it left by the value of A. A value of A of 32 or more gives 0.
- R10: A field size of 0 selects no bits. Both extracts then return 0, and replace returns A unchanged.
- R11: The engine register address output is always A plus the immediate. Class 5 returns the read data input as its result.
- R12: Classes 6 and 7, and class 0 functions 4 to 7 and 13 to 31, return 0, raise the illegal flag, and leave the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Instruction executes this cycle; enables the carry update |
| carry_clr | input | 1 | Synchronous carry clear for program start |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | Register A value |
| src_b_i | input | 32 | Register B value |
| result_o | output | 32 | Combinational result |
| illegal_o | output | 1 | Undefined class or function |
| carry_o | output | 1 | Current carry flag |
| rd_addr_o | output | 32 | Engine register read address |
| rd_data_i | input | 32 | Engine register read data, same cycle |

## Verification
The assertions assume that the instruction, the sources, the execute enable and the clear are known and stable around each rising edge. They also assume that the engine register file returns its data in the same cycle the address appears, since the result is checked against that data before the edge. The bench changes every input only on the falling edge. Its read-data model is a fixed combinational function of the address, so the same-cycle assumption always holds. Shift operands are drawn from small ranges and also from 32 and above, so that the saturation cases are exercised under these conditions.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned IMM_LSB = 14;

  typedef enum logic [2:0] {
    CLS_REGOP   = 3'd0,
    CLS_ADDI    = 3'd1,
    CLS_BF_INS  = 3'd2,
    CLS_BF_XIMM = 3'd3,
    CLS_BF_XREG = 3'd4,
    CLS_RDREG   = 3'd5,
    CLS_RSV6    = 3'd6,
    CLS_RSV7    = 3'd7
  } alu_class_e;

  localparam logic [4:0] FN_ADD  = 5'd0;
  localparam logic [4:0] FN_ADC  = 5'd1;
  localparam logic [4:0] FN_SUB  = 5'd2;
  localparam logic [4:0] FN_SBB  = 5'd3;
  localparam logic [4:0] FN_XOR  = 5'd8;
  localparam logic [4:0] FN_OR   = 5'd9;
  localparam logic [4:0] FN_AND  = 5'd10;
  localparam logic [4:0] FN_ANDN = 5'd11;
  localparam logic [4:0] FN_NAND = 5'd12;

  typedef enum logic [1:0] {
    BF_INSERT = 2'd0,
    BF_XIMM   = 2'd1,
    BF_XREG   = 2'd2
  } bf_kind_e;

  typedef struct packed {
    logic [4:0] dst_off;
    logic [4:0] size;
    logic [4:0] src_fn;
    logic [2:0] reg_b;
    logic [2:0] reg_a;
    logic [2:0] reg_d;
    logic       last;
    logic [2:0] assign_op;
    logic       spare;
    logic [2:0] cls;
  } instr_t;
endpackage

// File: rtl/macro_alu_regop.sv
module macro_alu_regop
  import macro_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [4:0]        fn_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              carry_we_o,
  output logic              legal_o
);
  localparam int unsigned EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic [EXT_W-1:0] cin_ext;
  logic [EXT_W-1:0] bin_ext;
  logic [EXT_W-1:0] wide;

  assign a_ext   = {1'b0, a_i};
  assign b_ext   = {1'b0, b_i};
  assign cin_ext = {{DATA_W{1'b0}}, carry_i};
  assign bin_ext = {{DATA_W{1'b0}}, ~carry_i};

  always_comb begin
    wide       = '0;
    res_o      = '0;
    carry_o    = carry_i;
    carry_we_o = 1'b0;
    legal_o    = 1'b1;
    case (fn_i)
      FN_ADD, FN_ADC: begin
        wide       = a_ext + b_ext + ((fn_i == FN_ADC) ? cin_ext : '0);
        res_o      = wide[DATA_W-1:0];
        carry_o    = wide[DATA_W];
        carry_we_o = 1'b1;
      end
      FN_SUB, FN_SBB: begin
        wide       = a_ext - b_ext - ((fn_i == FN_SBB) ? bin_ext : '0);
        res_o      = wide[DATA_W-1:0];
        carry_o    = ~wide[DATA_W];
        carry_we_o = 1'b1;
      end
      FN_XOR:  res_o = a_i ^ b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_ANDN: res_o = a_i & ~b_i;
      FN_NAND: res_o = ~(a_i & b_i);
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/macro_alu_bitfield.sv
module macro_alu_bitfield
  import macro_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  bf_kind_e          kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [4:0]        src_off_i,
  input  logic [4:0]        size_i,
  input  logic [4:0]        dst_off_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned SHW = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W;

  logic [DATA_W:0]   one_sh;
  logic [DATA_W-1:0] mask;
  logic              a_over;
  logic [SHW-1:0]    a_sh;
  logic [DATA_W-1:0] fld_src;
  logic [DATA_W-1:0] fld_a;

  always_comb begin
    one_sh  = (DATA_W+1)'(1) << size_i;
    mask    = one_sh[DATA_W-1:0] - DATA_W'(1);
    a_over  = (a_i >= LIMIT);
    a_sh    = a_i[SHW-1:0];
    fld_src = (b_i >> src_off_i) & mask;
    fld_a   = (b_i >> a_sh) & mask;
    case (kind_i)
      BF_INSERT: res_o = (a_i & ~(mask << dst_off_i)) | (fld_src << dst_off_i);
      BF_XIMM:   res_o = a_over ? '0 : (fld_a << dst_off_i);
      BF_XREG:   res_o = a_over ? '0 : (fld_src << a_sh);
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic              carry_clr,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o,
  output logic              carry_o,
  output logic [DATA_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int unsigned IMM_W = INSTR_W - IMM_LSB;

  instr_t            ins;
  alu_class_e        cls;
  logic [DATA_W-1:0] imm;
  logic [DATA_W-1:0] reg_res;
  logic              reg_cout;
  logic              reg_cwe;
  logic              reg_legal;
  logic [DATA_W-1:0] bf_res;
  bf_kind_e          bf_kind;
  logic              carry_q;
  logic              carry_d;

  assign ins = instr_t'(instr_i);
  assign cls = alu_class_e'(ins.cls);
  assign imm = {{(DATA_W-IMM_W){instr_i[INSTR_W-1]}}, instr_i[INSTR_W-1:IMM_LSB]};

  macro_alu_regop #(.DATA_W(DATA_W)) u_regop (
    .a_i        (src_a_i),
    .b_i        (src_b_i),
    .fn_i       (ins.src_fn),
    .carry_i    (carry_q),
    .res_o      (reg_res),
    .carry_o    (reg_cout),
    .carry_we_o (reg_cwe),
    .legal_o    (reg_legal)
  );

  always_comb begin
    case (cls)
      CLS_BF_XIMM: bf_kind = BF_XIMM;
      CLS_BF_XREG: bf_kind = BF_XREG;
      default:     bf_kind = BF_INSERT;
    endcase
  end

  macro_alu_bitfield #(.DATA_W(DATA_W)) u_bitfield (
    .kind_i    (bf_kind),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .src_off_i (ins.src_fn),
    .size_i    (ins.size),
    .dst_off_i (ins.dst_off),
    .res_o     (bf_res)
  );

  assign rd_addr_o = src_a_i + imm;

  always_comb begin
    result_o  = '0;
    illegal_o = 1'b0;
    case (cls)
      CLS_REGOP: begin
        result_o  = reg_legal ? reg_res : '0;
        illegal_o = ~reg_legal;
      end
      CLS_ADDI:                            result_o = src_a_i + imm;
      CLS_BF_INS, CLS_BF_XIMM, CLS_BF_XREG: result_o = bf_res;
      CLS_RDREG:                           result_o = rd_data_i;
      default:                             illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    carry_d = carry_q;
    if (carry_clr) begin
      carry_d = 1'b0;
    end else if (exec_en && (cls == CLS_REGOP) && reg_cwe) begin
      carry_d = reg_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
    end else begin
      carry_q <= carry_d;
    end
  end

  assign carry_o = carry_q;

  // R6: a clear request empties the carry on the next edge
  p_clear_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |=> !carry_o);

  // R5: without an executed arithmetic function the carry holds
  p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_clr && !(exec_en && instr_i[2:0] == 3'd0 && instr_i[21:19] == 3'd0))
    |=> $stable(carry_o));

  // R12: an undefined encoding never leaks a value
  p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (result_o == '0));

  // R11: engine read returns the external data unchanged
  p_read_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[2:0] == 3'd5) |-> (result_o == rd_data_i && !illegal_o));

  // R10: a zero-width extract yields nothing
  p_empty_extract_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((instr_i[2:0] == 3'd3 || instr_i[2:0] == 3'd4) && instr_i[26:22] == 5'd0)
    |-> (result_o == '0));
endmodule

// File: tb/macro_alu_tb_top.sv
module macro_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic        carry_clr;
  logic [31:0] instr;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] result;
  logic        illegal;
  logic        carry;
  logic [31:0] rd_addr;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit m_carry = 1'b0;
  bit done = 1'b0;
  int cycles = 0;

  localparam logic [31:0] RD_KEY = 32'hC3A5_0F1E;

  always #4 clk = ~clk;

  assign rd_data = rd_addr ^ RD_KEY;

  macro_alu dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_en   (exec_en),
    .carry_clr (carry_clr),
    .instr_i   (instr),
    .src_a_i   (src_a),
    .src_b_i   (src_b),
    .result_o  (result),
    .illegal_o (illegal),
    .carry_o   (carry),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk_bf(input int cls, input int fn, input int size, input int dst);
    logic [31:0] w;
    w = '0;
    w[2:0] = cls[2:0];
    w[21:17] = fn[4:0];
    w[26:22] = size[4:0];
    w[31:27] = dst[4:0];
    return w;
  endfunction

  function automatic logic [31:0] mk_imm(input int cls, input int imm18);
    logic [31:0] w;
    w = '0;
    w[2:0] = cls[2:0];
    w[31:14] = imm18[17:0];
    return w;
  endfunction

  function automatic logic [31:0] imm_of(input logic [31:0] op);
    logic signed [31:0] s;
    s = op;
    return s >>> 14;
  endfunction

  function automatic string tag_of(input logic [31:0] op);
    int c = op[2:0];
    int f = op[21:17];
    if (c == 0) begin
      if (f < 2) return "R3";
      if (f < 4) return "R4";
      if (f >= 8 && f <= 12) return "R2";
      return "R12";
    end
    if (c == 1) return "R1";
    if ((c == 2 || c == 3 || c == 4) && op[26:22] == 0) return "R10";
    if (c == 2) return "R7";
    if (c == 3) return "R8";
    if (c == 4) return "R9";
    if (c == 5) return "R11";
    return "R12";
  endfunction

  task automatic model(input logic [31:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit cin, output logic [31:0] res, output bit cout,
                       output bit ill, output bit cwe);
    int c = op[2:0];
    int f = op[21:17];
    int sz = op[26:22];
    int so = op[21:17];
    int dof = op[31:27];
    longint s;
    logic [31:0] m;
    res = 0; cout = cin; ill = 0; cwe = 0;
    m = (sz == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - sz));
    case (c)
      0: begin
        if (f == 0 || f == 1) begin
          s = longint'(a) + longint'(b) + ((f == 1 && cin) ? 1 : 0);
          res = s[31:0]; cout = (s > 64'sh0_FFFF_FFFF); cwe = 1;
        end else if (f == 2 || f == 3) begin
          s = longint'(a) - longint'(b) - ((f == 3 && !cin) ? 1 : 0);
          res = s[31:0]; cout = (s >= 0); cwe = 1;
        end else if (f == 8) res = a ^ b;
        else if (f == 9) res = a | b;
        else if (f == 10) res = a & b;
        else if (f == 11) res = a & ~b;
        else if (f == 12) res = ~(a & b);
        else ill = 1;
      end
      1: res = a + imm_of(op);
      2: res = (a & ~(m << dof)) | (((b >> so) & m) << dof);
      3: res = (a >= 32) ? 0 : (((b >> a) & m) << dof);
      4: res = (a >= 32) ? 0 : (((b >> so) & m) << a);
      5: res = (a + imm_of(op)) ^ RD_KEY;
      default: ill = 1;
    endcase
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] op, input logic [31:0] a, input logic [31:0] b,
                     input bit en, input bit clr);
    logic [31:0] e_res;
    bit e_cout, e_ill, e_cwe;
    string ctag;
    @(negedge clk);
    instr = op; src_a = a; src_b = b; exec_en = en; carry_clr = clr;
    #1;
    model(op, a, b, m_carry, e_res, e_cout, e_ill, e_cwe);
    check(tag_of(op), "result", result, e_res);
    check(tag_of(op), "illegal", {31'b0, illegal}, {31'b0, e_ill});
    if (op[2:0] == 3'd5) check("R11", "rd_addr", rd_addr, a + imm_of(op));
    if (clr) ctag = "R6";
    else if (en && e_cwe) ctag = tag_of(op);
    else ctag = "R5";
    if (clr) m_carry = 0;
    else if (en && e_cwe) m_carry = e_cout;
    @(posedge clk);
    #1;
    check(ctag, "carry", {31'b0, carry}, {31'b0, m_carry});
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 0; carry_clr = 0; instr = 0; src_a = 0; src_b = 0;
    repeat (3) @(posedge clk);
    #1 check("R6", "reset carry", {31'b0, carry}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R3 add overflow then carry-in
    run(mk_bf(0, 0, 0, 0), 32'hFFFF_FFFF, 32'h1, 1, 0);
    run(mk_bf(0, 1, 0, 0), 32'h0, 32'h0, 1, 0);
    run(mk_bf(0, 1, 0, 0), 32'h8000_0000, 32'h8000_0000, 1, 0);
    // R4 subtract and borrow sense
    run(mk_bf(0, 2, 0, 0), 32'd3, 32'd5, 1, 0);
    run(mk_bf(0, 3, 0, 0), 32'd10, 32'd3, 1, 0);
    run(mk_bf(0, 2, 0, 0), 32'd5, 32'd3, 1, 0);
    run(mk_bf(0, 3, 0, 0), 32'd10, 32'd3, 1, 0);
    // R5 idle and logic keep the carry
    run(mk_bf(0, 2, 0, 0), 32'd1, 32'd2, 0, 0);
    run(mk_bf(0, 8, 0, 0), 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 0);
    // R2 logic set
    for (int f = 9; f <= 12; f++) run(mk_bf(0, f, 0, 0), 32'hA5A5_00FF, 32'h0F0F_F0F0, 1, 0);
    // R6 clear beats an arithmetic update
    run(mk_bf(0, 0, 0, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
    run(mk_bf(0, 0, 0, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    // R1 add immediate, negative
    run(mk_imm(1, 18'h3FFFC), 32'd100, 32'd0, 1, 0);
    run(mk_imm(1, 18'h1FFFF), 32'h1, 32'd0, 1, 0);
    // R7 replace, R8/R9 extracts
    run(mk_bf(2, 4, 8, 16), 32'hFFFF_FFFF, 32'h0000_AB30, 1, 0);
    run(mk_bf(3, 0, 4, 28), 32'd8, 32'h0000_0F00, 1, 0);
    run(mk_bf(3, 0, 4, 0), 32'd40, 32'hFFFF_FFFF, 1, 0);
    run(mk_bf(4, 4, 12, 0), 32'd20, 32'h00AB_CDE0, 1, 0);
    run(mk_bf(4, 0, 8, 0), 32'd32, 32'hFFFF_FFFF, 1, 0);
    // R10 empty field
    run(mk_bf(2, 3, 0, 5), 32'h1234_5678, 32'hFFFF_FFFF, 1, 0);
    run(mk_bf(3, 0, 0, 5), 32'd1, 32'hFFFF_FFFF, 1, 0);
    // R11 engine read
    run(mk_imm(5, 18'h00040), 32'h0000_1000, 32'd0, 1, 0);
    // R12 undefined encodings keep carry
    run(mk_bf(0, 0, 0, 0), 32'hFFFF_FFFF, 32'h1, 1, 0);
    run(mk_bf(6, 0, 0, 0), 32'h1, 32'h1, 1, 0);
    run(mk_bf(0, 5, 0, 0), 32'h1, 32'h1, 1, 0);
    run(mk_bf(0, 20, 0, 0), 32'h1, 32'h1, 1, 0);
    run(mk_bf(7, 0, 0, 0), 32'h1, 32'h1, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] op, a, b;
      op = $urandom;
      if ($urandom_range(0, 3) == 0) op[21:17] = 5'($urandom_range(0, 12));
      a = $urandom;
      if ($urandom_range(0, 1) == 1) a = 32'($urandom_range(0, 40));
      b = $urandom;
      run(op, a, b, $urandom_range(0, 5) != 0, $urandom_range(0, 15) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule